// File: doc/BRIEF.md
# Seed-Ordered Cone Clustering Engine

This block turns one event's calorimeter towers into a short list of energy clusters. The towers are written into an internal 24 x 24 (eta by phi) tower store. Each one carries a transverse energy (Et) and two flags. A tower flagged as a seed is also inserted into a seed list that is kept in decreasing-Et order as it is loaded. When `start` is pulsed, the engine visits the seeds from highest to lowest Et. A seed that an earlier cluster has already swallowed is skipped. For any other seed, the engine steps through a fixed table of eta/phi offsets that describe the cone, one offset per clock. It adds the Et of every flagged tower not yet claimed, and marks each added tower as claimed.

Each finished cluster is placed into a second sorted list. Clustering stops when the seeds run out or when the cluster limit is reached. The clusters are then streamed out one per clock in decreasing Et, followed by a one-cycle done pulse that carries the cluster count. At that point the tower store and both lists are emptied, ready for the next event.

Top module: `cc_cone_engine`

## Requirements
- R1: While idle, a cycle with `wr_en` high stores `wr_et` and the seed/shoulder flags at tower (`wr_eta`, `wr_phi`), with eta and phi each in 0..23. A tower with `wr_seed` high also enters the seed list. The list keeps the MAX_SEEDS (32) highest seeds. Each tower is written at most once per event.
- R2: Seeds are visited in decreasing Et. Seeds of equal Et are visited in the order they were loaded.
- R3: The cone around a seed at (e, p) holds the offsets (de, dp) with de*de + dp*dp <= 5: 21 positions, including the seed itself. Phi wraps modulo 24. Eta does not wrap, so offsets that leave 0..23 in eta contribute nothing.
- R4: A cluster's Et is the sum of the Et of the towers in its cone that are flagged seed or shoulder and not yet claimed. A tower with neither flag contributes nothing and never forms a cluster.
- R5: Every tower added to a cluster is claimed. Later cones do not count a claimed tower, and a seed that is already claimed when its turn comes forms no cluster.
- R6: At most MAX_CLU (20) clusters are formed. Once the limit is reached, the remaining seeds are not processed.
- R7: Clusters are emitted one per clock with `clu_valid` high. Each carries its Et and its seed's coordinates on `clu_eta`/`clu_phi`. They come out in decreasing Et, and clusters of equal Et come out in the order they were formed.
- R8: `done` is high for exactly one cycle: the cycle right after the last valid cluster, or right after the seed walk when no cluster exists. In that cycle `clu_count` equals the number of clusters emitted. `busy` is high from the cycle after `start` until `done`, and is low in the `done` cycle. After reset, `busy`, `clu_valid` and `done` are low.
- R9: At `done` the tower store, the claimed marks and both lists are cleared. The next event sees only towers loaded after that point.
- R10: `wr_en` and `start` are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Tower write strobe |
| wr_eta | input | 5 | Eta index of the written tower |
| wr_phi | input | 5 | Phi index of the written tower |
| wr_et | input | 10 | Et of the written tower |
| wr_seed | input | 1 | Tower is a seed |
| wr_shoulder | input | 1 | Tower is a shoulder |
| start | input | 1 | Begin clustering of the loaded event |
| busy | output | 1 | Clustering or emission in progress |
| clu_valid | output | 1 | A cluster is presented this cycle |
| clu_et | output | 15 | Cluster Et |
| clu_eta | output | 5 | Eta of the cluster's seed |
| clu_phi | output | 5 | Phi of the cluster's seed |
| done | output | 1 | One-cycle end-of-event pulse |
| clu_count | output | 5 | Number of clusters of the event, valid with done |

## Verification
The clustering is tried on several patterns, each meant to separate one behaviour from its likely faults:
- Two overlapping seeds with nearby shoulders and a flag-free tower: shows that the weaker seed is absorbed rather than forming a second cluster, and that unflagged Et is excluded.
- Two seeds sharing one shoulder, plus a rich low seed: the higher seed must win the shared tower, and the output order must differ from the formation order.
- A seed at phi 0 with towers at phi 22/23 and a tower at eta 23: tells a correct phi wrap from a missing one, and shows that eta does not wrap.
- Equal-Et seeds and equal-Et clusters: tie ordering follows load order and formation order.

Directed runs then cover 22 isolated seeds against the limit of 20, an event with shoulders but no seeds, and a write issued while busy followed by an empty event, which exposes both an accepted write and a store that was not cleared.

// File: rtl/cc_pkg.sv
// Package cc_pkg
// Shared geometry and cone definitions for the cone clustering engine.
// Assumes a rectangular eta/phi tower grid; phi is periodic, eta is not.
package cc_pkg;
    localparam int ETA_N     = 24;   // towers along eta
    localparam int PHI_N     = 24;   // towers along phi (periodic)
    localparam int ET_W      = 10;   // tower Et width
    localparam int CONE_SPAN = 2;    // largest |offset| in either index
    localparam int CONE_R2   = 5;    // squared cone radius in index units

    localparam int ETA_W  = $clog2(ETA_N);
    localparam int PHI_W  = $clog2(PHI_N);
    localparam int POS_W  = ETA_W + PHI_W;
    localparam int TWR_N  = ETA_N * PHI_N;
    localparam int ADDR_W = $clog2(TWR_N);
    localparam int OFF_W  = $clog2(CONE_SPAN + 1) + 1;

    typedef struct packed {
        logic signed [OFF_W-1:0] de;
        logic signed [OFF_W-1:0] dp;
    } cone_off_t;

    // Number of offsets that fall inside the cone
    function automatic int cone_count();
        int n;
        n = 0;
        for (int de = -CONE_SPAN; de <= CONE_SPAN; de++)
            for (int dp = -CONE_SPAN; dp <= CONE_SPAN; dp++)
                if (de * de + dp * dp <= CONE_R2) n++;
        return n;
    endfunction

    localparam int CONE_N = cone_count();
    localparam int CONE_W = $clog2(CONE_N);
    localparam int SUM_W  = ET_W + $clog2(CONE_N + 1);

    // k-th in-cone offset in raster order
    function automatic cone_off_t cone_offset(int k);
        cone_off_t r;
        int n;
        r = '0;
        n = 0;
        for (int de = -CONE_SPAN; de <= CONE_SPAN; de++)
            for (int dp = -CONE_SPAN; dp <= CONE_SPAN; dp++)
                if (de * de + dp * dp <= CONE_R2) begin
                    if (n == k) begin
                        r.de = OFF_W'(de);
                        r.dp = OFF_W'(dp);
                    end
                    n++;
                end
        return r;
    endfunction

    // Flat tower store address of (eta, phi)
    function automatic logic [ADDR_W-1:0] twr_addr(logic [ETA_W-1:0] e,
                                                    logic [PHI_W-1:0] p);
        return ADDR_W'(e) * ADDR_W'(PHI_N) + ADDR_W'(p);
    endfunction
endpackage

// File: rtl/cc_cone_rom.sv
// Module cc_cone_rom
// Neighbour table: maps an entry number to the eta/phi offset of one cone
// position. The contents are computed from the package cone constants.
// Assumes idx < CONE_N; larger indices return a zero offset.
module cc_cone_rom
    import cc_pkg::*;
(
    input  logic [CONE_W-1:0] idx,
    output cone_off_t         off
);
    cone_off_t tbl [CONE_N];

    for (genvar g = 0; g < CONE_N; g++) begin : g_tbl
        // One constant table entry per cone position
        assign tbl[g] = cone_offset(g);
    end

    // Table read
    assign off = (int'(idx) < CONE_N) ? tbl[idx] : '0;
endmodule

// File: rtl/cc_sorted_list.sv
// Module cc_sorted_list
// Keeps up to DEPTH (key, tag) pairs in decreasing key order and accepts
// one insertion per clock. A new pair goes after every stored pair with an
// equal key, so ties keep arrival order. When full, the smallest pair falls
// off; a new pair that is not above the last stored key is dropped.
// Assumes clr and ins_en are not raised in the same cycle.
module cc_sorted_list #(
    parameter  int DEPTH = 32,
    parameter  int KEY_W = 10,
    parameter  int TAG_W = 10,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ins_en,
    input  logic [KEY_W-1:0] ins_key,
    input  logic [TAG_W-1:0] ins_tag,
    input  logic [CNT_W-1:0] rd_idx,
    output logic [KEY_W-1:0] rd_key,
    output logic [TAG_W-1:0] rd_tag,
    output logic [CNT_W-1:0] cnt
);
    logic [KEY_W-1:0] key_q  [DEPTH];
    logic [TAG_W-1:0] tag_q  [DEPTH];
    logic [KEY_W-1:0] prv_key[DEPTH];
    logic [TAG_W-1:0] prv_tag[DEPTH];
    logic [DEPTH-1:0] beats;   // new pair belongs at or above this slot
    logic [DEPTH-1:0] first;   // this slot takes the new pair
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] rd_sel;

    // Slot comparison against the incoming key
    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            beats[i] = (CNT_W'(i) >= cnt_q) || (ins_key > key_q[i]);
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        if (g == 0) begin : g_head
            // Head slot has no upper neighbour
            assign first[g]   = beats[g];
            assign prv_key[g] = ins_key;
            assign prv_tag[g] = ins_tag;
        end else begin : g_body
            // Other slots shift down from the slot above
            assign first[g]   = beats[g] && !beats[g-1];
            assign prv_key[g] = key_q[g-1];
            assign prv_tag[g] = tag_q[g-1];
        end
    end

    // Insertion with shift-down of the lower part
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                key_q[i] <= '0;
                tag_q[i] <= '0;
            end
        end else if (clr) begin
            cnt_q <= '0;
        end else if (ins_en) begin
            cnt_q <= (cnt_q == CNT_W'(DEPTH)) ? cnt_q : cnt_q + 1'b1;
            for (int i = 0; i < DEPTH; i++) begin
                if (beats[i]) begin
                    key_q[i] <= first[i] ? ins_key : prv_key[i];
                    tag_q[i] <= first[i] ? ins_tag : prv_tag[i];
                end
            end
        end
    end

    // Read port
    assign rd_sel = rd_idx[IDX_W-1:0];
    assign rd_key = (int'(rd_idx) < DEPTH) ? key_q[rd_sel] : '0;
    assign rd_tag = (int'(rd_idx) < DEPTH) ? tag_q[rd_sel] : '0;
    assign cnt    = cnt_q;

    // Stored keys never increase down the list (R2 for seeds, R7 for clusters)
    for (genvar g = 0; g < DEPTH - 1; g++) begin : g_chk
        always_ff @(posedge clk) begin
            if (rst_n && (CNT_W'(g + 1) < cnt_q))
                p_keys_desc_r2: assert (key_q[g] >= key_q[g+1])
                    else $error("list order broken at slot %0d", g);
        end
    end
endmodule

// File: rtl/cc_cone_engine.sv
// Module cc_cone_engine
// Cone clustering of one event. Towers are loaded while idle. Seeds are
// kept sorted on load. After start, seeds are visited in decreasing Et and
// each unclaimed seed sums its cone, one neighbour-table entry per clock.
// Clusters are sorted as they form, then streamed out, then a done pulse
// follows and all event state is cleared.
// Assumes each tower is written at most once per event.
module cc_cone_engine
    import cc_pkg::*;
#(
    parameter  int MAX_SEEDS = 32,
    parameter  int MAX_CLU   = 20,
    localparam int SCNT_W    = $clog2(MAX_SEEDS + 1),
    localparam int CCNT_W    = $clog2(MAX_CLU + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ETA_W-1:0]  wr_eta,
    input  logic [PHI_W-1:0]  wr_phi,
    input  logic [ET_W-1:0]   wr_et,
    input  logic              wr_seed,
    input  logic              wr_shoulder,
    input  logic              start,
    output logic              busy,
    output logic              clu_valid,
    output logic [SUM_W-1:0]  clu_et,
    output logic [ETA_W-1:0]  clu_eta,
    output logic [PHI_W-1:0]  clu_phi,
    output logic              done,
    output logic [CCNT_W-1:0] clu_count
);
    typedef enum logic [1:0] {S_LOAD, S_PICK, S_CONE, S_EMIT} state_t;

    state_t            st;
    logic [ET_W-1:0]   twr_et   [TWR_N];
    logic [TWR_N-1:0]  twr_cone;   // seed or shoulder
    logic [TWR_N-1:0]  twr_used;   // claimed by a cluster

    logic [SCNT_W-1:0] sp, seed_cnt;
    logic [POS_W-1:0]  sd_tag;
    logic [ET_W-1:0]   sd_key;
    logic [ADDR_W-1:0] sd_addr;
    logic              pick_end;

    logic [CONE_W-1:0] k;
    cone_off_t         off;
    logic [ETA_W-1:0]  cur_eta;
    logic [PHI_W-1:0]  cur_phi;
    logic [SUM_W-1:0]  acc, sum_next;
    int                nb_e, nb_p;
    logic              nb_in, member, cone_last;
    logic [ADDR_W-1:0] nb_addr;

    logic [CCNT_W-1:0] op, clu_cnt;
    logic [SUM_W-1:0]  cl_key;
    logic [POS_W-1:0]  cl_tag;
    logic              emit_end, load_wr;

    assign load_wr   = (st == S_LOAD) && wr_en;
    assign emit_end  = (st == S_EMIT) && (op == clu_cnt);
    assign cone_last = (st == S_CONE) && (k == CONE_W'(CONE_N - 1));
    assign busy      = (st != S_LOAD);

    // Seed list, sorted as towers are loaded
    cc_sorted_list #(.DEPTH(MAX_SEEDS), .KEY_W(ET_W), .TAG_W(POS_W)) u_seeds (
        .clk(clk), .rst_n(rst_n), .clr(emit_end),
        .ins_en(load_wr && wr_seed), .ins_key(wr_et), .ins_tag({wr_eta, wr_phi}),
        .rd_idx(sp), .rd_key(sd_key), .rd_tag(sd_tag), .cnt(seed_cnt)
    );

    // Cluster list, sorted as clusters complete
    cc_sorted_list #(.DEPTH(MAX_CLU), .KEY_W(SUM_W), .TAG_W(POS_W)) u_clus (
        .clk(clk), .rst_n(rst_n), .clr(emit_end),
        .ins_en(cone_last), .ins_key(sum_next), .ins_tag({cur_eta, cur_phi}),
        .rd_idx(op), .rd_key(cl_key), .rd_tag(cl_tag), .cnt(clu_cnt)
    );

    // Neighbour table lookup for the current cone step
    cc_cone_rom u_rom (.idx(k), .off(off));

    // Seed address and end-of-walk test
    always_comb begin
        sd_addr  = twr_addr(sd_tag[POS_W-1:PHI_W], sd_tag[PHI_W-1:0]);
        pick_end = (sp >= seed_cnt) || (clu_cnt >= CCNT_W'(MAX_CLU));
    end

    // Neighbour position with phi wrap and eta bound, plus the running sum
    always_comb begin
        nb_e = int'(cur_eta) + int'($signed(off.de));
        nb_p = int'(cur_phi) + int'($signed(off.dp));
        if (nb_p < 0)
            nb_p = nb_p + PHI_N;
        else if (nb_p >= PHI_N)
            nb_p = nb_p - PHI_N;
        nb_in    = (nb_e >= 0) && (nb_e < ETA_N);
        nb_addr  = nb_in ? twr_addr(ETA_W'(nb_e), PHI_W'(nb_p)) : '0;
        member   = nb_in && twr_cone[nb_addr] && !twr_used[nb_addr];
        sum_next = acc + (member ? SUM_W'(twr_et[nb_addr]) : '0);
    end

    // Tower store: load, claim, clear at end of event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            twr_cone <= '0;
            twr_used <= '0;
            for (int i = 0; i < TWR_N; i++) twr_et[i] <= '0;
        end else if (load_wr) begin
            twr_et[twr_addr(wr_eta, wr_phi)]   <= wr_et;
            twr_cone[twr_addr(wr_eta, wr_phi)] <= wr_seed | wr_shoulder;
            twr_used[twr_addr(wr_eta, wr_phi)] <= 1'b0;
        end else if ((st == S_CONE) && member) begin
            twr_used[nb_addr] <= 1'b1;
        end else if (emit_end) begin
            twr_cone <= '0;
            twr_used <= '0;
            for (int i = 0; i < TWR_N; i++) twr_et[i] <= '0;
        end
    end

    // Control: seed walk, cone stepping, emission and done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_LOAD;
            sp        <= '0;
            k         <= '0;
            acc       <= '0;
            cur_eta   <= '0;
            cur_phi   <= '0;
            op        <= '0;
            clu_valid <= 1'b0;
            clu_et    <= '0;
            clu_eta   <= '0;
            clu_phi   <= '0;
            done      <= 1'b0;
            clu_count <= '0;
        end else begin
            clu_valid <= 1'b0;
            done      <= 1'b0;
            case (st)
                S_LOAD: if (start) begin
                    st <= S_PICK;
                    sp <= '0;
                end
                S_PICK: if (pick_end) begin
                    st <= S_EMIT;
                    op <= '0;
                end else if (twr_used[sd_addr]) begin
                    sp <= sp + 1'b1;
                end else begin
                    st      <= S_CONE;
                    cur_eta <= sd_tag[POS_W-1:PHI_W];
                    cur_phi <= sd_tag[PHI_W-1:0];
                    k       <= '0;
                    acc     <= '0;
                end
                S_CONE: if (cone_last) begin
                    st <= S_PICK;
                    sp <= sp + 1'b1;
                end else begin
                    k   <= k + 1'b1;
                    acc <= sum_next;
                end
                S_EMIT: if (emit_end) begin
                    done      <= 1'b1;
                    clu_count <= clu_cnt;
                    st        <= S_LOAD;
                end else begin
                    clu_valid <= 1'b1;
                    clu_et    <= cl_key;
                    clu_eta   <= cl_tag[POS_W-1:PHI_W];
                    clu_phi   <= cl_tag[PHI_W-1:0];
                    op        <= op + 1'b1;
                end
                default: st <= S_LOAD;
            endcase
        end
    end

    // A cone is only summed while the cluster limit has room
    p_cone_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_CONE) |-> (clu_cnt < CCNT_W'(MAX_CLU)));

    // A claimed seed is passed over without starting a cone
    p_used_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PICK && !pick_end && twr_used[sd_addr]) |=> (st == S_PICK));

    // Emitted Et never rises within one stream
    p_emit_desc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clu_valid && $past(clu_valid)) |-> (clu_et <= $past(clu_et)));

    // Done lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Done never coincides with a cluster
    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!clu_valid && !busy));

    // Writes during a cone walk leave the seed list untouched
    p_busy_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st == S_CONE) |=> (seed_cnt == $past(seed_cnt)));
endmodule

// File: tb/cc_cone_engine_bench.sv
`timescale 1ns/1ps
module cc_cone_engine_bench;
    import cc_pkg::*;
    localparam int MAX_SEEDS = 32;
    localparam int MAX_CLU   = 20;
    localparam int CCNT_W    = $clog2(MAX_CLU + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, wr_seed = 1'b0, wr_shoulder = 1'b0, start = 1'b0;
    logic [ETA_W-1:0] wr_eta = '0;
    logic [PHI_W-1:0] wr_phi = '0;
    logic [ET_W-1:0]  wr_et = '0;
    logic busy, clu_valid, done;
    logic [SUM_W-1:0]  clu_et;
    logic [ETA_W-1:0]  clu_eta;
    logic [PHI_W-1:0]  clu_phi;
    logic [CCNT_W-1:0] clu_count;

    always #10 clk = ~clk;   // 50 MHz

    cc_cone_engine #(.MAX_SEEDS(MAX_SEEDS), .MAX_CLU(MAX_CLU)) u_cc_cone_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_eta(wr_eta), .wr_phi(wr_phi),
        .wr_et(wr_et), .wr_seed(wr_seed), .wr_shoulder(wr_shoulder), .start(start),
        .busy(busy), .clu_valid(clu_valid), .clu_et(clu_et), .clu_eta(clu_eta),
        .clu_phi(clu_phi), .done(done), .clu_count(clu_count)
    );

    int  n_chk = 0, n_bad = 0;
    bit  finished = 0;

    // Stimulus rows: {event[3:0], eta[4:0], phi[4:0], et[9:0], seed, shoulder}
    localparam int NV = 23;
    localparam logic [25:0] VEC [NV] = '{
        {4'd0, 5'd5,  5'd5,  10'd100, 1'b1, 1'b0},
        {4'd0, 5'd6,  5'd6,  10'd50,  1'b1, 1'b0},
        {4'd0, 5'd7,  5'd5,  10'd10,  1'b0, 1'b1},
        {4'd0, 5'd5,  5'd8,  10'd7,   1'b0, 1'b1},
        {4'd0, 5'd5,  5'd6,  10'd20,  1'b0, 1'b0},
        {4'd1, 5'd10, 5'd10, 10'd40,  1'b1, 1'b0},
        {4'd1, 5'd10, 5'd13, 10'd60,  1'b1, 1'b0},
        {4'd1, 5'd10, 5'd11, 10'd30,  1'b0, 1'b1},
        {4'd1, 5'd20, 5'd20, 10'd35,  1'b1, 1'b0},
        {4'd1, 5'd20, 5'd21, 10'd30,  1'b0, 1'b1},
        {4'd1, 5'd21, 5'd21, 10'd30,  1'b0, 1'b1},
        {4'd1, 5'd19, 5'd19, 10'd20,  1'b0, 1'b1},
        {4'd2, 5'd0,  5'd0,  10'd80,  1'b1, 1'b0},
        {4'd2, 5'd0,  5'd23, 10'd9,   1'b0, 1'b1},
        {4'd2, 5'd1,  5'd22, 10'd4,   1'b0, 1'b1},
        {4'd2, 5'd23, 5'd0,  10'd50,  1'b0, 1'b1},
        {4'd2, 5'd2,  5'd1,  10'd6,   1'b0, 1'b1},
        {4'd2, 5'd0,  5'd21, 10'd11,  1'b0, 1'b1},
        {4'd3, 5'd3,  5'd3,  10'd70,  1'b1, 1'b0},
        {4'd3, 5'd3,  5'd5,  10'd70,  1'b1, 1'b0},
        {4'd3, 5'd12, 5'd0,  10'd30,  1'b1, 1'b0},
        {4'd3, 5'd12, 5'd10, 10'd30,  1'b1, 1'b0},
        {4'd3, 5'd4,  5'd4,  10'd5,   1'b0, 1'b1}
    };

    // Shadow of the loaded event
    int sh_et [ETA_N][PHI_N];
    bit sh_fl [ETA_N][PHI_N];
    int sd_e[64], sd_p[64], sd_et[64];
    int sd_n = 0;
    // Expected clusters
    int ex_e[64], ex_p[64], ex_et[64];
    int ex_n = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_shadow();
        for (int e = 0; e < ETA_N; e++)
            for (int p = 0; p < PHI_N; p++) begin
                sh_et[e][p] = 0;
                sh_fl[e][p] = 0;
            end
        sd_n = 0;
    endtask

    // R1: one tower write, one clock wide
    task automatic put(int e, int p, int et, bit s, bit h);
        @(negedge clk);
        wr_en = 1'b1; wr_eta = ETA_W'(e); wr_phi = PHI_W'(p);
        wr_et = ET_W'(et); wr_seed = s; wr_shoulder = h;
        @(negedge clk);
        wr_en = 1'b0;
        sh_et[e][p] = et;
        sh_fl[e][p] = s | h;
        if (s) begin
            sd_e[sd_n] = e; sd_p[sd_n] = p; sd_et[sd_n] = et; sd_n++;
        end
    endtask

    function automatic bit in_cone(int se, int sp, int e, int p);
        int de, dp;
        de = (e > se) ? e - se : se - e;
        dp = (p > sp) ? p - sp : sp - p;
        if (dp > PHI_N / 2) dp = PHI_N - dp;
        return (de * de + dp * dp) <= CONE_R2;
    endfunction

    // Reference clustering computed from the requirements
    task automatic model();
        int oe[64], op_[64], oet[64], n, nf;
        int fe[64], fp[64], fet[64];
        bit used [ETA_N][PHI_N];
        n = sd_n;
        for (int i = 0; i < n; i++) begin oe[i] = sd_e[i]; op_[i] = sd_p[i]; oet[i] = sd_et[i]; end
        for (int i = 1; i < n; i++) begin
            int ke, kp, kt, j;
            ke = oe[i]; kp = op_[i]; kt = oet[i]; j = i - 1;
            while (j >= 0 && oet[j] < kt) begin
                oe[j+1] = oe[j]; op_[j+1] = op_[j]; oet[j+1] = oet[j]; j--;
            end
            oe[j+1] = ke; op_[j+1] = kp; oet[j+1] = kt;
        end
        if (n > MAX_SEEDS) n = MAX_SEEDS;
        nf = 0;
        for (int s = 0; s < n; s++) begin
            int sum;
            if (nf == MAX_CLU) break;
            if (used[oe[s]][op_[s]]) continue;
            sum = 0;
            for (int e = 0; e < ETA_N; e++)
                for (int p = 0; p < PHI_N; p++)
                    if (sh_fl[e][p] && !used[e][p] && in_cone(oe[s], op_[s], e, p)) begin
                        sum += sh_et[e][p];
                        used[e][p] = 1;
                    end
            fe[nf] = oe[s]; fp[nf] = op_[s]; fet[nf] = sum; nf++;
        end
        ex_n = 0;
        for (int i = 0; i < nf; i++) begin
            int j;
            j = ex_n - 1;
            while (j >= 0 && ex_et[j] < fet[i]) begin
                ex_e[j+1] = ex_e[j]; ex_p[j+1] = ex_p[j]; ex_et[j+1] = ex_et[j]; j--;
            end
            ex_e[j+1] = fe[i]; ex_p[j+1] = fp[i]; ex_et[j+1] = fet[i];
            ex_n++;
        end
    endtask

    // Start, collect the stream, compare with the model; optional write while busy
    task automatic run_event(bit inject);
        int got_e[64], got_p[64], got_et[64];
        int got_n, cyc, cnt_seen;
        bit seen_done, prev_valid, done_adj, busy_at_done;
        got_n = 0; cyc = 0; cnt_seen = -1;
        seen_done = 0; prev_valid = 0; done_adj = 0; busy_at_done = 1;
        model();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R8", "busy after start", int'(busy), 1);
        while (!seen_done && cyc < 4000) begin
            if (inject && cyc == 2) begin   // R10: write while busy
                wr_en = 1'b1; wr_eta = 5'd15; wr_phi = 5'd15;
                wr_et = 10'd99; wr_seed = 1'b1; wr_shoulder = 1'b0;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
            cyc++;
            if (clu_valid && got_n < 64) begin
                got_e[got_n] = int'(clu_eta); got_p[got_n] = int'(clu_phi);
                got_et[got_n] = int'(clu_et); got_n++;
            end
            if (done) begin
                seen_done = 1;
                done_adj = prev_valid || (ex_n == 0);
                cnt_seen = int'(clu_count);
                busy_at_done = busy;
            end
            prev_valid = clu_valid;
        end
        wr_en = 1'b0;
        chk(seen_done, "R8", "done seen (watchdog)", int'(seen_done), 1);
        chk(cnt_seen == ex_n, "R6 R8", "clu_count", cnt_seen, ex_n);
        chk(got_n == ex_n, "R6 R7", "clusters emitted", got_n, ex_n);
        chk(done_adj, "R8", "done right after last cluster", int'(done_adj), 1);
        chk(!busy_at_done, "R8", "busy low at done", int'(busy_at_done), 0);
        for (int i = 0; i < got_n && i < ex_n; i++) begin
            chk(got_et[i] == ex_et[i], "R3 R4 R5 R7", "cluster et", got_et[i], ex_et[i]);
            chk(got_e[i] == ex_e[i], "R2 R7", "cluster eta", got_e[i], ex_e[i]);
            chk(got_p[i] == ex_p[i], "R2 R7", "cluster phi", got_p[i], ex_p[i]);
        end
        clear_shadow();   // R9: the design empties its store at done
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clear_shadow();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk(busy == 1'b0, "R8", "reset busy", int'(busy), 0);
        chk(clu_valid == 1'b0, "R8", "reset clu_valid", int'(clu_valid), 0);
        chk(done == 1'b0, "R8", "reset done", int'(done), 0);

        // Table walk: R1 R2 R3 R4 R5 R7 on four events
        for (int i = 0; i < NV; i++) begin
            put(int'(VEC[i][21:17]), int'(VEC[i][16:12]), int'(VEC[i][11:2]),
                VEC[i][1], VEC[i][0]);
            if (i == NV - 1 || VEC[i+1][25:22] != VEC[i][25:22]) run_event(1'b0);
        end

        // R6: 22 isolated seeds against a limit of 20
        for (int i = 0; i < 22; i++) put(4 * (i % 6), 4 * (i / 6), 100 + i, 1'b1, 1'b0);
        run_event(1'b0);

        // R4 R8: shoulders only, no cluster
        put(8, 8, 40, 1'b0, 1'b1);
        put(9, 8, 40, 1'b0, 1'b1);
        run_event(1'b0);

        // R10: a seed written while busy is ignored
        put(2, 2, 50, 1'b1, 1'b0);
        run_event(1'b1);
        // R9 R10: nothing new loaded, so the next event must be empty
        run_event(1'b0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule